// File: doc/BRIEF.md
# Programmable Clock Output Router

This block turns two externally supplied clocks, a reference clock and a PLL clock, into the chip's clock outputs. It oversamples both clocks on the system clock. It divides either of them by twice a programmable value and picks a source for the main clock pin. It also drives one multifunction pad. That pad can be an output-enable input, a power-down input, a frequency-select input, or a second clock output with its own source choice.

Two configuration sets are held. Each set has a reference divider value and a feedback divider value, which go to the external PLL. Each set also has a local post-divide value and a main-output source. When the pad is used for frequency selection, its level picks the active set while the block is running. A change of post-divide value waits for the divider's terminal count, so the output never shows a runt pulse. A single write port with an address and data loads the configuration.

All pad-derived control goes through one register stage. Every output is a function of registered state only.

Top module: `clkrt_router`

## Requirements
- R1: After reset, both sets hold divider values 1 and source 0, the pad mode is 0 and the hi-Z bit is 1. Writes to addresses 0, 1 and 2 load the set-1 reference value (data[7:0]), feedback value (data[10:0]) and {source data[6:5], post value data[4:0]}. Addresses 3 to 5 do the same for set 2, and address 6 loads the global fields. The active set's reference and feedback values appear on `pll_r` and `pll_m`.
- R2: The post divider toggles its output every P rising edges of its input, giving a 50% duty cycle and a period of 2P input periods.
- R3: A post value of 0 divides exactly as a value of 1.
- R4: Main source code 0 selects the PLL clock divided by 2P, code 1 selects the reference clock, code 2 selects the reference clock divided by 2P, and code 3 acts as code 1.
- R5: In clock mode the pad is driven (`mf_oe`=1). Its source is set by global data[3:2]: 0 gives the reference clock, 1 gives the reference clock divided by 2, 2 gives the main clock, and 3 gives the main clock divided by 2.
- R6: Global data[1:0] sets the pad mode: 0 output enable, 1 power down, 2 frequency select, 3 clock output. In the three input modes `mf_oe` and `mf_out` stay 0.
- R7: In output-enable mode a sampled pad level of 0 forces `main_out` low, and a level of 1 gives normal operation.
- R8: In power-down mode a sampled pad level of 0 holds every divider counter and divided output at zero and disables the main output. After release, division restarts from a zero count.
- R9: In frequency-select mode a sampled pad level of 1 makes set 1 active and a level of 0 makes set 2 active. This affects `pll_r`, `pll_m`, the post value and the main source.
- R10: Global data[4] sets the main output's disabled state: 1 releases the pin (`main_oe`=0), 0 drives it low (`main_oe`=1, `main_out`=0).
- R11: When `mf_ext_drive` is 0 the pad reads as logic 1.
- R12: A new post value, from a write or a set change, takes effect only when the divider's count reaches its terminal value, or while it is held in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the clocks |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration write address |
| wr_data | input | 11 | Configuration write data |
| ref_clk | input | 1 | Reference clock |
| pll_clk | input | 1 | PLL output clock |
| mf_rx | input | 1 | Level received from the multifunction pad |
| mf_ext_drive | input | 1 | 1 when something outside drives the pad |
| pll_r | output | 8 | Active reference divider value for the PLL |
| pll_m | output | 11 | Active feedback divider value for the PLL |
| main_out | output | 1 | Main clock pin data |
| main_oe | output | 1 | Main clock pin output enable |
| mf_out | output | 1 | Multifunction pad data |
| mf_oe | output | 1 | Multifunction pad output enable |

## Verification
The hardest case to reach from the ports is a post value that changes partway through a divided period. The new value must be held back until the count wraps. The bench writes a larger value while the PLL path is dividing. It also switches the frequency-select pad between two sets with different post values while the clocks keep running. Its cycle-level model, which keeps its own pending divisor, then shows any early or late switch on the very next cycle. Power-down is entered and left while the clocks are running, so the restart from a zero count is seen as well.

// File: rtl/clkrt_pkg.sv
`timescale 1ns/1ps
package clkrt_pkg;
    localparam int R_W    = 8;
    localparam int M_W    = 11;
    localparam int P_W    = 5;
    localparam int NSETS  = 2;
    localparam int SEL_W  = $clog2(NSETS);
    localparam int FIELDS = 3;
    localparam int ADDR_W = 3;
    localparam int DATA_W = M_W;
    localparam int GLB_ADDR = FIELDS * NSETS;

    typedef enum logic [1:0] {
        PIN_OE   = 2'd0,
        PIN_PD   = 2'd1,
        PIN_FSEL = 2'd2,
        PIN_CLK  = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        MS_PLLDIV = 2'd0,
        MS_REF    = 2'd1,
        MS_REFDIV = 2'd2,
        MS_REFALT = 2'd3
    } main_src_e;

    typedef enum logic [1:0] {
        AS_REF      = 2'd0,
        AS_REFHALF  = 2'd1,
        AS_MAIN     = 2'd2,
        AS_MAINHALF = 2'd3
    } aux_src_e;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [P_W-1:0] p;
        main_src_e      src;
    } cfg_set_t;

    typedef struct packed {
        pin_mode_e mode;
        aux_src_e  aux;
        logic      hiz;
    } cfg_glb_t;

    function automatic logic [P_W-1:0] p_eff(input logic [P_W-1:0] p);
        return (p == '0) ? P_W'(1) : p;
    endfunction
endpackage

// File: rtl/clkrt_cfg_regs.sv
`timescale 1ns/1ps
module clkrt_cfg_regs
    import clkrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  set_sel,
    output cfg_set_t          act,
    output cfg_glb_t          glb
);
    cfg_set_t set_arr [NSETS];

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        localparam int BASE = FIELDS * s;
        cfg_set_t set_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                set_q <= '{r: R_W'(1), m: M_W'(1), p: P_W'(1), src: MS_PLLDIV};
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(BASE)) begin
                    set_q.r <= wr_data[R_W-1:0];
                end else if (wr_addr == ADDR_W'(BASE + 1)) begin
                    set_q.m <= wr_data[M_W-1:0];
                end else if (wr_addr == ADDR_W'(BASE + 2)) begin
                    set_q.p   <= wr_data[P_W-1:0];
                    set_q.src <= main_src_e'(wr_data[P_W+1:P_W]);
                end
            end
        end
        assign set_arr[s] = set_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glb <= '{mode: PIN_OE, aux: AS_REF, hiz: 1'b1};
        end else if (wr_en && wr_addr == ADDR_W'(GLB_ADDR)) begin
            glb.mode <= pin_mode_e'(wr_data[1:0]);
            glb.aux  <= aux_src_e'(wr_data[3:2]);
            glb.hiz  <= wr_data[4];
        end
    end

    assign act = set_arr[set_sel];
endmodule

// File: rtl/clkrt_post_div.sv
`timescale 1ns/1ps
module clkrt_post_div
    import clkrt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic           tick,
    input  logic [P_W-1:0] p_next,
    output logic           q,
    output logic [P_W-1:0] cnt,
    output logic [P_W-1:0] lim
);
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
            q   <= 1'b0;
            lim <= p_eff(p_next);
        end else if (tick) begin
            if (cnt == lim - P_W'(1)) begin
                cnt <= '0;
                q   <= ~q;
                lim <= p_eff(p_next);
            end else begin
                cnt <= cnt + P_W'(1);
            end
        end
    end
endmodule

// File: rtl/clkrt_half_div.sv
`timescale 1ns/1ps
module clkrt_half_div (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic lvl,
    output logic q
);
    logic prev;
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            prev <= 1'b0;
            q    <= 1'b0;
        end else begin
            prev <= lvl;
            if (lvl && !prev) q <= ~q;
        end
    end
endmodule

// File: rtl/clkrt_router.sv
`timescale 1ns/1ps
module clkrt_router
    import clkrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_clk,
    input  logic              pll_clk,
    input  logic              mf_rx,
    input  logic              mf_ext_drive,
    output logic [R_W-1:0]    pll_r,
    output logic [M_W-1:0]    pll_m,
    output logic              main_out,
    output logic              main_oe,
    output logic              mf_out,
    output logic              mf_oe
);
    localparam int NDIV = 2;   // index 0: PLL path, index 1: reference path

    logic ref_s, pll_s, pin_s;
    logic pin_raw;
    cfg_set_t act;
    cfg_glb_t glb;
    logic [SEL_W-1:0] set_sel;
    logic pd, en;
    logic [NDIV-1:0] tick, div_q, half_in, half_q;
    logic [P_W-1:0] div_cnt [NDIV];
    logic [P_W-1:0] div_lim [NDIV];
    logic main_lvl, aux_lvl;

    // An undriven pad reads high, as a pull-up would make it.
    assign pin_raw = mf_ext_drive ? mf_rx : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_s <= 1'b0;
            pll_s <= 1'b0;
            pin_s <= 1'b1;
        end else begin
            ref_s <= ref_clk;
            pll_s <= pll_clk;
            pin_s <= pin_raw;
        end
    end

    assign set_sel = SEL_W'((glb.mode == PIN_FSEL) && !pin_s);
    assign pd      = (glb.mode == PIN_PD) && !pin_s;
    assign en      = !(((glb.mode == PIN_OE) || (glb.mode == PIN_PD)) && !pin_s);

    clkrt_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .set_sel (set_sel),
        .act     (act),
        .glb     (glb)
    );

    assign tick[0] = pll_clk && !pll_s;
    assign tick[1] = ref_clk && !ref_s;

    for (genvar k = 0; k < NDIV; k++) begin : g_div
        clkrt_post_div u_div (
            .clk    (clk),
            .rst    (rst),
            .hold   (pd),
            .tick   (tick[k]),
            .p_next (act.p),
            .q      (div_q[k]),
            .cnt    (div_cnt[k]),
            .lim    (div_lim[k])
        );
    end

    always_comb begin
        unique case (act.src)
            MS_PLLDIV: main_lvl = div_q[0];
            MS_REFDIV: main_lvl = div_q[1];
            default:   main_lvl = ref_s;
        endcase
    end

    assign half_in[0] = main_lvl;
    assign half_in[1] = ref_clk;

    for (genvar h = 0; h < NDIV; h++) begin : g_half
        clkrt_half_div u_half (
            .clk  (clk),
            .rst  (rst),
            .hold (pd),
            .lvl  (half_in[h]),
            .q    (half_q[h])
        );
    end

    always_comb begin
        unique case (glb.aux)
            AS_REF:      aux_lvl = ref_s;
            AS_REFHALF:  aux_lvl = half_q[1];
            AS_MAIN:     aux_lvl = main_lvl;
            default:     aux_lvl = half_q[0];
        endcase
    end

    assign pll_r    = act.r;
    assign pll_m    = act.m;
    assign main_out = en && main_lvl;
    assign main_oe  = en || !glb.hiz;
    assign mf_oe    = (glb.mode == PIN_CLK);
    assign mf_out   = mf_oe && aux_lvl;
endmodule

// File: rtl/clkrt_router_chk.sv
`timescale 1ns/1ps
module clkrt_router_chk
    import clkrt_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           main_out,
    input logic           main_oe,
    input logic           mf_out,
    input logic           mf_oe,
    input cfg_glb_t       glb,
    input logic           pin_s,
    input logic [P_W-1:0] cnt0,
    input logic [P_W-1:0] cnt1,
    input logic [P_W-1:0] lim0,
    input logic [P_W-1:0] lim1,
    input logic           q0,
    input logic           q1
);
    p_released_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !main_oe |-> !main_out);

    p_oe_low_disables_r7: assert property (@(posedge clk) disable iff (rst)
        (glb.mode == PIN_OE && !pin_s) |-> !main_out);

    p_input_mode_undriven_r6: assert property (@(posedge clk) disable iff (rst)
        (glb.mode != PIN_CLK) |-> (!mf_oe && !mf_out));

    p_count_below_limit_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt0 < lim0) && (cnt1 < lim1));

    p_zero_post_as_one_r3: assert property (@(posedge clk) disable iff (rst)
        (lim0 != '0) && (lim1 != '0));

    p_powerdown_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (glb.mode == PIN_PD && !pin_s) |=> (cnt0 == '0 && cnt1 == '0 && !q0 && !q1));
endmodule

bind clkrt_router clkrt_router_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .main_out (main_out),
    .main_oe  (main_oe),
    .mf_out   (mf_out),
    .mf_oe    (mf_oe),
    .glb      (glb),
    .pin_s    (pin_s),
    .cnt0     (div_cnt[0]),
    .cnt1     (div_cnt[1]),
    .lim0     (div_lim[0]),
    .lim1     (div_lim[1]),
    .q0       (div_q[0]),
    .q1       (div_q[1])
);

// File: tb/test_clkrt_router.sv
`timescale 1ns/1ps
module test_clkrt_router;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic ref_clk = 1'b0, pll_clk = 1'b0, mf_rx = 1'b0, mf_ext_drive = 1'b0;
    logic [7:0] pll_r;
    logic [10:0] pll_m;
    logic main_out, main_oe, mf_out, mf_oe;

    always #2.5 clk = ~clk;

    clkrt_router i_clkrt_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_clk(ref_clk), .pll_clk(pll_clk), .mf_rx(mf_rx), .mf_ext_drive(mf_ext_drive),
        .pll_r(pll_r), .pll_m(pll_m), .main_out(main_out), .main_oe(main_oe),
        .mf_out(mf_out), .mf_oe(mf_oe)
    );

    int n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    int s_r[2], s_m[2], s_p[2], s_src[2];
    int g_mode, g_aux, g_hiz;
    bit m_ref_s, m_pll_s, m_pin_s;
    int cnt[2], lim[2];
    bit q[2];
    bit mprev, mhalf, rprev, rhalf;
    int gr = 0, gp = 0, pll_hp = 1, ref_hp = 3;

    function automatic int peff(int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int cur_set();
        return (g_mode == 2 && !m_pin_s) ? 1 : 0;
    endfunction

    function automatic bit mlevel();
        int s = s_src[cur_set()];
        if (s == 0) return q[0];
        if (s == 2) return q[1];
        return m_ref_s;
    endfunction

    task automatic model_step();
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                s_r[i] = 1; s_m[i] = 1; s_p[i] = 1; s_src[i] = 0;
                cnt[i] = 0; lim[i] = 1; q[i] = 0;
            end
            g_mode = 0; g_aux = 0; g_hiz = 1;
            m_ref_s = 0; m_pll_s = 0; m_pin_s = 1;
            mprev = 0; mhalf = 0; rprev = 0; rhalf = 0;
        end else begin
            bit pd = (g_mode == 1) && !m_pin_s;
            int pn = peff(s_p[cur_set()]);
            bit ml = mlevel();
            bit tk[2];
            tk[0] = pll_clk && !m_pll_s;
            tk[1] = ref_clk && !m_ref_s;
            for (int k = 0; k < 2; k++) begin
                if (pd) begin
                    cnt[k] = 0; q[k] = 0; lim[k] = pn;
                end else if (tk[k]) begin
                    if (cnt[k] >= lim[k] - 1) begin
                        cnt[k] = 0; q[k] = !q[k]; lim[k] = pn;
                    end else cnt[k]++;
                end
            end
            if (pd) begin
                mprev = 0; mhalf = 0; rprev = 0; rhalf = 0;
            end else begin
                if (ml && !mprev) mhalf = !mhalf;
                mprev = ml;
                if (ref_clk && !rprev) rhalf = !rhalf;
                rprev = ref_clk;
            end
            m_ref_s = ref_clk; m_pll_s = pll_clk;
            m_pin_s = mf_ext_drive ? mf_rx : 1'b1;
            if (wr_en) begin
                if (wr_addr == 6) begin
                    g_mode = wr_data[1:0]; g_aux = wr_data[3:2]; g_hiz = wr_data[4];
                end else if (wr_addr < 6) begin
                    int st = wr_addr / 3;
                    case (wr_addr % 3)
                        0: s_r[st] = wr_data[7:0];
                        1: s_m[st] = wr_data[10:0];
                        default: begin s_p[st] = wr_data[4:0]; s_src[st] = wr_data[6:5]; end
                    endcase
                end
            end
        end
    endtask

    task automatic compare();
        bit en = !((g_mode == 0 || g_mode == 1) && !m_pin_s);
        bit ml = mlevel();
        bit ea, e_moe, e_mout, e_foe, e_fout;
        int es = cur_set();
        case (g_aux)
            0: ea = m_ref_s;
            1: ea = rhalf;
            2: ea = ml;
            default: ea = mhalf;
        endcase
        e_mout = en && ml;
        e_moe = en || !g_hiz;
        e_foe = (g_mode == 3);
        e_fout = e_foe && ea;
        n_checks++;
        if (main_out !== e_mout || main_oe !== e_moe || mf_oe !== e_foe || mf_out !== e_fout
            || pll_r !== 8'(s_r[es]) || pll_m !== 11'(s_m[es])) begin
            n_errors++;
            $display("FAIL %s t=%0t out/oe/mfout/mfoe/r/m got %b%b%b%b %0d %0d exp %b%b%b%b %0d %0d",
                cur_req, $time, main_out, main_oe, mf_out, mf_oe, pll_r, pll_m,
                e_mout, e_moe, e_fout, e_foe, s_r[es], s_m[es]);
        end
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        if (++gp >= pll_hp) begin gp = 0; pll_clk = !pll_clk; end
        if (++gr >= ref_hp) begin gr = 0; ref_clk = !ref_clk; end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 11'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk(bit ok, string req, int got, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        cur_req = "R1";
        chk(pll_r == 8'd1, "R1 reset pll_r", pll_r, 1);
        chk(pll_m == 11'd1, "R1 reset pll_m", pll_m, 1);
        chk(mf_oe == 1'b0, "R1 reset mf_oe", mf_oe, 0);
        wr(0, 'h25); wr(1, 'h3A7);
        run(1);
        chk(pll_r == 8'h25, "R1 write pll_r", pll_r, 'h25);
        chk(pll_m == 11'h3A7, "R1 write pll_m", pll_m, 'h3A7);

        cur_req = "R2"; wr(2, (0 << 5) | 3); run(60);
        pll_hp = 2; run(60); pll_hp = 1;
        cur_req = "R3"; wr(2, (0 << 5) | 0); run(30);
        cur_req = "R4"; wr(2, (1 << 5) | 2); run(30);
        wr(2, (2 << 5) | 2); run(60);
        wr(2, (3 << 5) | 2); run(30);
        cur_req = "R12"; wr(2, (0 << 5) | 2); run(13);
        wr(2, (0 << 5) | 5); run(50);
        wr(2, (2 << 5) | 1); run(7);
        wr(2, (2 << 5) | 4); run(60);

        cur_req = "R9";
        wr(3, 'h11); wr(4, 'h0FF); wr(5, (0 << 5) | 3);
        wr(2, (0 << 5) | 6);
        mf_ext_drive = 1'b1; mf_rx = 1'b1;
        wr(6, 2); run(20);
        chk(pll_r == 8'h25, "R9 pin1 set1 r", pll_r, 'h25);
        mf_rx = 1'b0; run(2);
        chk(pll_r == 8'h11, "R9 pin0 set2 r", pll_r, 'h11);
        chk(pll_m == 11'h0FF, "R9 pin0 set2 m", pll_m, 'hFF);
        run(40); mf_rx = 1'b1; run(9); mf_rx = 1'b0; run(23); mf_rx = 1'b1; run(30);

        cur_req = "R11"; mf_rx = 1'b0; mf_ext_drive = 1'b0; run(3);
        chk(pll_r == 8'h25, "R11 floating pad picks set1", pll_r, 'h25);

        cur_req = "R7"; wr(2, (1 << 5) | 1); wr(6, 0 | (1 << 4));
        mf_ext_drive = 1'b1; mf_rx = 1'b1; run(20);
        mf_rx = 1'b0; run(2);
        chk(main_out == 1'b0, "R7 pin0 main_out", main_out, 0);
        cur_req = "R10";
        chk(main_oe == 1'b0, "R10 hiz disable oe", main_oe, 0);
        run(10); wr(6, 0); run(2);
        chk(main_oe == 1'b1 && main_out == 1'b0, "R10 drive-low disable", main_oe, 1);
        mf_rx = 1'b1; run(20);

        cur_req = "R8"; wr(2, (0 << 5) | 3); wr(6, 1 | (1 << 4)); run(17);
        mf_rx = 1'b0; run(25);
        chk(main_oe == 1'b0, "R8 power-down oe", main_oe, 0);
        mf_rx = 1'b1; run(50);
        wr(2, (2 << 5) | 2); run(11); mf_rx = 1'b0; run(9); mf_rx = 1'b1; run(40);

        cur_req = "R6"; wr(6, 2); run(5);
        chk(mf_oe == 1'b0, "R6 fsel mode pad input", mf_oe, 0);
        cur_req = "R5"; wr(6, 3 | (0 << 2)); run(2);
        chk(mf_oe == 1'b1, "R5 clock mode pad driven", mf_oe, 1);
        run(40);
        wr(6, 3 | (1 << 2)); run(50);
        wr(6, 3 | (2 << 2)); run(50);
        wr(6, 3 | (3 << 2)); run(80);
        wr(2, (0 << 5) | 2); run(60);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog %s got 0 exp 1", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule